// File: doc/BRIEF.md
# SMM Halt Restart Controller

This block follows the run state of a simple processor core. The core is either executing, halted, or inside system-management mode (SMM). When an SMI request arrives, the controller makes one write to the halt-restart word in the SMM state-save area. That write records whether the core was halted at the moment of the interrupt. The controller then holds the core in SMM until a resume request arrives.

On resume, the controller reads the same word back. The service routine may have rewritten the word in the meantime. Bit 0 of the read data alone decides where the core goes next. If bit 0 is set, the core returns to the halted state. The halt instruction is not fetched again; instead, a halt special bus cycle is requested once. If bit 0 is clear, the fetch unit is told to continue from the saved state. While the core is halted, a wake interrupt sends it back to executing.

Top module: `smm_halt_restart`

## Requirements
- R1: When reset is released, `core_state_o` is 0 (executing), both pulse outputs are low, and `mem_req_o` is low.
- R2: In the executing state, a `halt_exec_i` pulse with no SMI moves `core_state_o` to 1 (halted) on the next cycle. In the halted state, `halt_exec_i` has no effect.
- R3: In the halted state, a `wake_irq_i` pulse with no SMI moves the core to executing. `fetch_resume_o` is high for exactly the first executing cycle. In the executing state, `wake_irq_i` is ignored.
- R4: An SMI is accepted in both the executing and the halted state, and it wins over a halt or wake pulse in the same cycle. In the next cycle there is exactly one write (`mem_req_o`=1, `mem_we_o`=1) to address `SAVE_BASE + 0xFF02`. After that write, `core_state_o` reads 2 (SMM).
- R5: The word written on entry has bit 0 = 1 when the SMI was taken from the halted state and bit 0 = 0 otherwise. Bits 15..1 are written as zero.
- R6: While in SMM, and during the save, read and decide steps, the inputs `smi_req_i`, `halt_exec_i` and `wake_irq_i` are ignored. `core_state_o` stays 2.
- R7: A `resume_i` pulse in SMM produces one read (`mem_req_o`=1, `mem_we_o`=0) to the same address in the next cycle. The read data is sampled on `mem_rdata_i` in the cycle after the read. The decision is made one cycle later. Only bit 0 of the read data is used.
- R8: If the sampled bit 0 is 1, the core enters the halted state. `halt_cycle_o` is high for exactly its first halted cycle, and `fetch_resume_o` stays low.
- R9: If the sampled bit 0 is 0, the core enters the executing state. `fetch_resume_o` is high for exactly its first executing cycle, and `halt_cycle_o` stays low.
- R10: If software overwrites the word with 0x00FF while in SMM, the resume goes to the halted state even when SMM was entered from executing.
- R11: `halt_cycle_o` and `fetch_resume_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_exec_i | input | 1 | Pulse: the halt instruction has executed |
| smi_req_i | input | 1 | Pulse: system-management interrupt request |
| resume_i | input | 1 | Pulse: return from SMM |
| wake_irq_i | input | 1 | Pulse: interrupt that wakes a halted core |
| mem_req_o | output | 1 | State-save memory access strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Address of the halt-restart word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| halt_cycle_o | output | 1 | Pulse: request a halt special bus cycle |
| fetch_resume_o | output | 1 | Pulse: tell the fetch unit to continue |
| core_state_o | output | 2 | 0 executing, 1 halted, 2 SMM |

## Verification
The assertions check every cycle that:
- the two pulse outputs never coincide;
- each pulse lines up with the state it announces;
- the save write is always followed by SMM, and a read is always followed by the sample step;
- the decision bit equals bit 0 of the data that came back.

Only the bench scenarios can show the following:
- the written word really reflects the halted/executing origin;
- a software rewrite to 0x00FF, or to a word with high bits set and bit 0 clear, steers the return;
- the stray pulses sent during SMM leave no trace.

// File: rtl/smm_hr_pkg.sv
// Shared types for the SMM halt restart controller.
// Assumes a 16-bit halt-restart word at a fixed offset from the save base.
package smm_hr_pkg;
    localparam int unsigned HR_WORD_W = 16;
    localparam logic [15:0] HR_OFFSET = 16'hFF02;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_SAVE,
        ST_SMM,
        ST_LOAD,
        ST_SAMPLE,
        ST_DECIDE
    } ctl_state_t;

    typedef enum logic [1:0] {
        RS_EXEC = 2'd0,
        RS_HALT = 2'd1,
        RS_SMM  = 2'd2
    } run_state_t;
endpackage

// File: rtl/smm_hr_fsm.sv
// Run-state sequencer: executing, halted, and the SMM entry/exit steps.
// Assumes single-cycle request pulses and a one-cycle memory read latency.
module smm_hr_fsm
    import smm_hr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_i,
    input  logic       smi_i,
    input  logic       rsm_i,
    input  logic       wake_i,
    input  logic       resume_halt_i,
    output ctl_state_t state_o,
    output logic       from_halt_o,
    output logic       halt_cycle_o,
    output logic       fetch_resume_o
);
    ctl_state_t state_q, state_d;
    logic       smi_take;

    assign smi_take = smi_i && (state_q == ST_RUN || state_q == ST_HALT);

    // Next-state selection; SMI outranks halt and wake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (smi_i) state_d = ST_SAVE;
                       else if (halt_i) state_d = ST_HALT;
            ST_HALT:   if (smi_i) state_d = ST_SAVE;
                       else if (wake_i) state_d = ST_RUN;
            ST_SAVE:   state_d = ST_SMM;
            ST_SMM:    if (rsm_i) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_DECIDE;
            ST_DECIDE: state_d = resume_halt_i ? ST_HALT : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State register plus origin flag and single-cycle pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_RUN;
            from_halt_o    <= 1'b0;
            halt_cycle_o   <= 1'b0;
            fetch_resume_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (smi_take) from_halt_o <= (state_q == ST_HALT);
            halt_cycle_o   <= (state_q == ST_DECIDE) && resume_halt_i;
            fetch_resume_o <= ((state_q == ST_DECIDE) && !resume_halt_i) ||
                              ((state_q == ST_HALT) && wake_i && !smi_i);
        end
    end

    assign state_o = state_q;

    // R4: the save step is only ever reached from executing or halted.
    p_save_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE) |-> ($past(state_q) == ST_RUN || $past(state_q) == ST_HALT));
    // R4: the save step always lands in SMM.
    p_save_to_smm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAVE) |=> (state_q == ST_SMM));
    // R5: an SMI taken while halted records a halted origin.
    p_origin_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && smi_i) |=> from_halt_o);
    // R6: SMM is only left through a resume request.
    p_smm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SMM && !rsm_i) |=> (state_q == ST_SMM));
endmodule

// File: rtl/smm_hr_port.sv
// State-save port: drives the halt-restart word access and captures bit 0.
// Assumes read data is valid in the cycle after the read strobe.
module smm_hr_port
    import smm_hr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SAVE_BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_state_t           state_i,
    input  logic                 from_halt_i,
    input  logic [HR_WORD_W-1:0] rdata_i,
    output logic                 req_o,
    output logic                 we_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [HR_WORD_W-1:0] wdata_o,
    output logic                 resume_halt_o
);
    localparam logic [ADDR_W-1:0] HR_ADDR = SAVE_BASE + ADDR_W'(HR_OFFSET);

    // Access strobes and the entry word, upper bits forced to zero.
    always_comb begin
        req_o   = (state_i == ST_SAVE) || (state_i == ST_LOAD);
        we_o    = (state_i == ST_SAVE);
        addr_o  = HR_ADDR;
        wdata_o = '0;
        if (state_i == ST_SAVE) wdata_o = {{(HR_WORD_W-1){1'b0}}, from_halt_i};
    end

    // Capture the restart decision bit in the sample step.
    always_ff @(posedge clk) begin
        if (!rst_n) resume_halt_o <= 1'b0;
        else if (state_i == ST_SAMPLE) resume_halt_o <= rdata_i[0];
    end

    // R7: the decision bit equals bit 0 of the returned data.
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_DECIDE) |-> (resume_halt_o == $past(rdata_i[0])));
    // R7: the read step comes straight after SMM and leads to the sample step.
    p_load_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_LOAD) |-> ($past(state_i) == ST_SMM));
    p_load_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_LOAD) |=> (state_i == ST_SAMPLE));
endmodule

// File: rtl/smm_halt_restart.sv
// Top level: SMM halt restart controller.
// Assumes pulse inputs of one cycle and a synchronous active-low reset.
module smm_halt_restart
    import smm_hr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SAVE_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_exec_i,
    input  logic              smi_req_i,
    input  logic              resume_i,
    input  logic              wake_irq_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic [15:0]       mem_rdata_i,
    output logic              halt_cycle_o,
    output logic              fetch_resume_o,
    output logic [1:0]        core_state_o
);
    ctl_state_t state;
    logic       from_halt;
    logic       resume_halt;

    smm_hr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt_i        (halt_exec_i),
        .smi_i         (smi_req_i),
        .rsm_i         (resume_i),
        .wake_i        (wake_irq_i),
        .resume_halt_i (resume_halt),
        .state_o       (state),
        .from_halt_o   (from_halt),
        .halt_cycle_o  (halt_cycle_o),
        .fetch_resume_o(fetch_resume_o)
    );

    smm_hr_port #(.ADDR_W(ADDR_W), .SAVE_BASE(SAVE_BASE)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state),
        .from_halt_i  (from_halt),
        .rdata_i      (mem_rdata_i),
        .req_o        (mem_req_o),
        .we_o         (mem_we_o),
        .addr_o       (mem_addr_o),
        .wdata_o      (mem_wdata_o),
        .resume_halt_o(resume_halt)
    );

    // Collapse internal steps into the three visible run states.
    always_comb begin
        unique case (state)
            ST_RUN:  core_state_o = RS_EXEC;
            ST_HALT: core_state_o = RS_HALT;
            default: core_state_o = RS_SMM;
        endcase
    end

    // R11: never both pulses together.
    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_cycle_o && fetch_resume_o));
    // R8: a halt cycle request coincides with the halted state.
    p_halt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cycle_o |-> (core_state_o == RS_HALT));
    // R9: a fetch resume coincides with the executing state.
    p_fetch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_resume_o |-> (core_state_o == RS_EXEC));
    // R4: memory is touched only while in SMM.
    p_mem_in_smm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (core_state_o == RS_SMM));
endmodule

// File: tb/sim_smm_halt_restart.sv
module sim_smm_halt_restart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_exec = 1'b0, smi = 1'b0, rsm = 1'b0, wake = 1'b0;
    logic        mem_req, mem_we, halt_cycle, fetch_resume;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] rdata = 16'h0;
    logic [15:0] mem_word = 16'h0;
    logic [1:0]  core_state;
    logic        sw_we = 1'b0;
    logic [15:0] sw_data = 16'h0;
    int          n_cmp = 0, n_bad = 0;
    int          m_st = 0, m_from = 0, m_flag = 0, m_hc = 0, m_fr = 0;

    always #4 clk = ~clk;

    smm_halt_restart u0 (
        .clk(clk), .rst_n(rst_n), .halt_exec_i(halt_exec), .smi_req_i(smi),
        .resume_i(rsm), .wake_irq_i(wake), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
        .halt_cycle_o(halt_cycle), .fetch_resume_o(fetch_resume),
        .core_state_o(core_state)
    );

    // state-save memory: one-cycle read latency, software poke port
    always @(posedge clk) begin
        if (mem_req && mem_we) mem_word <= mem_wdata;
        else if (sw_we) mem_word <= sw_data;
        if (mem_req && !mem_we) rdata <= mem_word;
    end

    // behavioural reference model (0 run,1 halt,2 save,3 smm,4 read,5 sample,6 decide)
    always @(posedge clk) begin
        m_hc = 0; m_fr = 0;
        if (!rst_n) begin
            m_st = 0; m_from = 0; m_flag = 0;
        end else begin
            case (m_st)
                0: if (smi) begin m_from = 0; m_st = 2; end else if (halt_exec) m_st = 1;
                1: if (smi) begin m_from = 1; m_st = 2; end
                   else if (wake) begin m_st = 0; m_fr = 1; end
                2: m_st = 3;
                3: if (rsm) m_st = 4;
                4: m_st = 5;
                5: begin m_flag = int'(rdata[0]); m_st = 6; end
                default: if (m_flag != 0) begin m_st = 1; m_hc = 1; end
                         else begin m_st = 0; m_fr = 1; end
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 core_state", 32'(core_state), (m_st <= 1) ? m_st : 2);
            chk("R8 halt_cycle", 32'(halt_cycle), m_hc);
            chk("R9 fetch_resume", 32'(fetch_resume), m_fr);
            chk("R7 mem_req", 32'(mem_req), (m_st == 2 || m_st == 4) ? 1 : 0);
            chk("R4 mem_we", 32'(mem_we), (m_st == 2) ? 1 : 0);
            if (mem_req) chk("R4 addr", 32'(mem_addr), 32'hFF02);
            if (mem_req && mem_we) chk("R5 wdata", 32'(mem_wdata), m_from);
            chk("R11 exclusive", 32'(halt_cycle & fetch_resume), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic h, input logic s, input logic r, input logic w);
        halt_exec = h; smi = s; rsm = r; wake = w;
        @(negedge clk);
        halt_exec = 0; smi = 0; rsm = 0; wake = 0;
    endtask

    task automatic poke(input logic [15:0] v);
        sw_data = v; sw_we = 1;
        @(negedge clk);
        sw_we = 0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 state", 32'(core_state), 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 pulses", 32'(halt_cycle | fetch_resume), 0);
        pulse(0, 0, 0, 1); cyc(1);
        chk("R3 wake in run ignored", 32'(core_state), 0);
        pulse(1, 0, 0, 0); cyc(1);
        chk("R2 halt entered", 32'(core_state), 1);
        pulse(1, 0, 0, 0); cyc(1);
        chk("R2 halt in halt", 32'(core_state), 1);
        pulse(0, 0, 0, 1);
        chk("R3 fetch resume", 32'(fetch_resume), 1);
        cyc(1);
        // SMI from run beats a halt pulse
        pulse(1, 1, 0, 0); cyc(2);
        chk("R4 in smm", 32'(core_state), 2);
        chk("R5 saved from run", 32'(mem_word), 16'h0000);
        pulse(1, 1, 0, 1); cyc(2);
        chk("R6 ignored in smm", 32'(core_state), 2);
        pulse(0, 0, 1, 0); cyc(4);
        chk("R9 back to run", 32'(core_state), 0);
        // SMI from halt, return to halt
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0); cyc(2);
        chk("R5 saved from halt", 32'(mem_word), 16'h0001);
        pulse(0, 0, 1, 0); cyc(4);
        chk("R8 back to halt", 32'(core_state), 1);
        pulse(0, 0, 0, 1); cyc(1);
        // software forces return to halt from run origin
        pulse(0, 1, 0, 0); cyc(2);
        poke(16'h00FF); cyc(1);
        pulse(0, 0, 1, 0); cyc(4);
        chk("R10 forced halt", 32'(core_state), 1);
        // SMI with wake in halt; software writes high bits, bit 0 clear
        pulse(0, 1, 0, 1); cyc(2);
        chk("R4 smi beats wake", 32'(core_state), 2);
        chk("R5 word from halt", 32'(mem_word), 16'h0001);
        poke(16'hFFFE); cyc(1);
        pulse(0, 0, 1, 0); cyc(4);
        chk("R7 only bit0 used", 32'(core_state), 0);
        cyc(3);
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end
endmodule